// File: doc/BRIEF.md
# Servo Cycle Sequencer

This block paces one iteration of a multi-channel digital servo from a free-running slot counter on the real-time I/O clock (125 MHz in the target system). Every iteration has the same length, `CYCLE_LEN` slots, and each stage is tied to a fixed slot or a bounded window of slots:

- An ADC convert strobe is issued first.
- A shift-start strobe follows, which begins the serial read-out.
- Once the capture logic reports that all channels are in, a filter-start strobe is issued. A channel address then walks over the shared filter's RAMs, one channel per clock.
- At the fixed update slot, a DDS-start strobe is issued, provided the filter has reported completion.

If either handshake arrives too late, the stage that needs it is skipped for that iteration and a sticky overrun flag is raised. This keeps the timing of later iterations fixed.

The behaviour is a seven-state machine. Its states and transitions are:

- `ST_IDLE`: entered after reset or while enable is low.
- `ST_ARMED`: entered on the convert slot from any state.
- `ST_CAPTURE`: entered from `ST_ARMED` on the shift slot.
- `ST_WALK`: entered from `ST_CAPTURE` when capture-done arrives in time.
- `ST_SETTLE`: entered from `ST_WALK` on the last channel address.
- `ST_READY`: entered from `ST_SETTLE` on filter-done.
- `ST_DONE`: entered after the DDS strobe or after an overrun skip. It stays there until the next convert slot.

Lowering enable returns any state to `ST_IDLE`. Channel counts of 16 and 8 are both supported through `N_CH`.

Top module: `servo_cycle_seq`

## Requirements
- R1: While enabled, the slot counter runs 0 to `CYCLE_LEN`-1 and wraps. The convert strobe is high in slot `CONV_AT` of every iteration, so at slots 0 and 64 with the defaults.
- R2: The shift-start strobe is high in slot `SHIFT_AT` (default 4), after the convert strobe of the same iteration.
- R3: A capture-done pulse is accepted only after shift start. A pulse sampled at the end of slot c gives a filter-start strobe in slot c+1, if c+1 is at most `FILT_LATEST` (default 30). A pulse before shift start is ignored.
- R4: The channel-valid output is high for exactly `N_CH` cycles, starting in the filter-start cycle. The channel address reads 0, 1, … `N_CH`-1 over those cycles.
- R5: A filter-done pulse sampled after the walk ends, at the end of a slot no later than `DDS_AT`-1 (default 55), gives a DDS-start strobe in slot `DDS_AT` (default 56).
- R6: If no filter start has happened by slot `FILT_LATEST`, the overrun flag rises in slot `FILT_LATEST`+1. In that case no filter start, no address walk and no DDS start occur in that iteration.
- R7: If filter-done has not been seen after the walk by the end of slot `DDS_AT`-1, the overrun flag rises in slot `DDS_AT` and no DDS start is issued. Filter-done pulses during the walk are ignored.
- R8: The overrun flag stays high until reset, including across the next iteration.
- R9: While enable is low, the counter holds at zero and no strobe or channel-valid is issued. The first enabled cycle is slot 0, so its convert strobe comes at once when `CONV_AT` is 0.
- R10: Each strobe is one clock wide, and no two strobes are high in the same cycle.
- R11: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Real-time I/O clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| cap_done_i | input | 1 | All channels captured, one-cycle pulse |
| filt_done_i | input | 1 | Filter finished, one-cycle pulse |
| conv_o | output | 1 | ADC convert strobe |
| shift_o | output | 1 | ADC data shift-start strobe |
| filt_start_o | output | 1 | Filter stage start strobe |
| dds_start_o | output | 1 | DDS update start strobe |
| chan_o | output | $clog2(N_CH) | Channel address into the filter RAMs |
| chan_vld_o | output | 1 | Channel address valid |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The assertions rely on three things about the inputs and parameters:

- Both done inputs are synchronous to the clock.
- The parameters keep the slots in order: convert before shift, shift before the filter deadline, and the deadline plus `N_CH` before the DDS slot.
- Only under that ordering are the strobes mutually exclusive and is the walk always finished before the DDS slot.

The stimulus runs only the default parameter set. It drives every done input as a single-cycle pulse, set away from the clock edge in a chosen slot. Each iteration is placed on a fresh reset, so every overrun case starts from a cleared flag.

// File: rtl/svc_pkg.sv
package svc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_CAPTURE,
        ST_WALK,
        ST_SETTLE,
        ST_READY,
        ST_DONE
    } svc_state_e;

endpackage

// File: rtl/svc_slot_counter.sv
module svc_slot_counter #(
    parameter int CYCLE_LEN = 64,
    parameter int CNT_W     = $clog2(CYCLE_LEN)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_nxt_o
);

    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(CYCLE_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // The first enabled cycle is slot zero; afterwards step and wrap.
    always_comb begin
        if (!en_i || !run_q) begin
            cnt_nxt_o = '0;
        end else if (cnt_q == LAST_SLOT) begin
            cnt_nxt_o = '0;
        end else begin
            cnt_nxt_o = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt_o;
            run_q <= en_i;
        end
    end

    // R1
    cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && run_q && cnt_q == LAST_SLOT) |=> (cnt_q == '0));

    // R9
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (cnt_q == '0));

endmodule

// File: rtl/svc_chan_walker.sv
module svc_chan_walker #(
    parameter int N_CH = 16,
    parameter int CH_W = $clog2(N_CH)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            en_i,
    input  logic            go_i,
    output logic [CH_W-1:0] addr_o,
    output logic            vld_o,
    output logic            last_o
);

    logic [CH_W-1:0] addr_q;
    logic            vld_q;
    logic            at_top;

    // A power-of-two count ends on all-ones; other counts compare.
    generate
        if ((N_CH & (N_CH - 1)) == 0) begin : g_pow2
            assign at_top = &addr_q;
        end else begin : g_cmp
            assign at_top = (addr_q == CH_W'(N_CH - 1));
        end
    endgenerate

    assign last_o = vld_q && at_top;
    assign addr_o = addr_q;
    assign vld_o  = vld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            addr_q <= '0;
            vld_q  <= 1'b0;
        end else if (!en_i) begin
            addr_q <= '0;
            vld_q  <= 1'b0;
        end else if (go_i) begin
            addr_q <= '0;
            vld_q  <= 1'b1;
        end else if (vld_q) begin
            if (at_top) begin
                addr_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    // R4
    chan_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_q && !at_top && en_i && !go_i) |=>
            (vld_q && (addr_q - $past(addr_q)) == CH_W'(1)));

    // R4
    chan_begin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (go_i && en_i) |=> (vld_q && addr_q == '0));

endmodule

// File: rtl/svc_phase_fsm.sv
module svc_phase_fsm
    import svc_pkg::*;
#(
    parameter int CYCLE_LEN   = 64,
    parameter int CONV_AT     = 0,
    parameter int SHIFT_AT    = 4,
    parameter int FILT_LATEST = 30,
    parameter int DDS_AT      = 56,
    parameter int CNT_W       = $clog2(CYCLE_LEN)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    input  logic             cap_done_i,
    input  logic             filt_done_i,
    input  logic             walk_last_i,
    output logic             go_walk_o,
    output logic             conv_o,
    output logic             shift_o,
    output logic             filt_o,
    output logic             dds_o,
    output logic             ovr_o
);

    localparam logic [CNT_W-1:0] SLOT_CONV  = CNT_W'(CONV_AT);
    localparam logic [CNT_W-1:0] SLOT_SHIFT = CNT_W'(SHIFT_AT);
    localparam logic [CNT_W-1:0] SLOT_FLAST = CNT_W'(FILT_LATEST);
    localparam logic [CNT_W-1:0] SLOT_FMISS = CNT_W'(FILT_LATEST + 1);
    localparam logic [CNT_W-1:0] SLOT_DDS   = CNT_W'(DDS_AT);

    svc_state_e st_q, st_n;
    logic conv_q, shift_q, filt_q, dds_q, ovr_q;
    logic conv_n, shift_n, filt_n, dds_n, ovr_n;

    // Next state and next strobes, decided against the count of the
    // coming cycle so each strobe is aligned with its own slot.
    always_comb begin
        st_n      = st_q;
        conv_n    = 1'b0;
        shift_n   = 1'b0;
        filt_n    = 1'b0;
        dds_n     = 1'b0;
        ovr_n     = ovr_q;
        go_walk_o = 1'b0;
        if (!en_i) begin
            st_n = ST_IDLE;
        end else if (cnt_nxt_i == SLOT_CONV) begin
            st_n   = ST_ARMED;
            conv_n = 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_DONE: begin
                    st_n = st_q;
                end
                ST_ARMED: begin
                    if (cnt_nxt_i == SLOT_SHIFT) begin
                        st_n    = ST_CAPTURE;
                        shift_n = 1'b1;
                    end
                end
                ST_CAPTURE: begin
                    if (cap_done_i && cnt_nxt_i <= SLOT_FLAST) begin
                        st_n      = ST_WALK;
                        filt_n    = 1'b1;
                        go_walk_o = 1'b1;
                    end else if (cnt_nxt_i == SLOT_FMISS) begin
                        st_n  = ST_DONE;
                        ovr_n = 1'b1;
                    end
                end
                ST_WALK: begin
                    if (walk_last_i) begin
                        st_n = ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (cnt_nxt_i == SLOT_DDS) begin
                        st_n = ST_DONE;
                        if (filt_done_i) begin
                            dds_n = 1'b1;
                        end else begin
                            ovr_n = 1'b1;
                        end
                    end else if (filt_done_i) begin
                        st_n = ST_READY;
                    end
                end
                ST_READY: begin
                    if (cnt_nxt_i == SLOT_DDS) begin
                        st_n  = ST_DONE;
                        dds_n = 1'b1;
                    end
                end
                default: begin
                    st_n = ST_IDLE;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_n;
        end
    end

    // Output registers.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            conv_q  <= 1'b0;
            shift_q <= 1'b0;
            filt_q  <= 1'b0;
            dds_q   <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            conv_q  <= conv_n;
            shift_q <= shift_n;
            filt_q  <= filt_n;
            dds_q   <= dds_n;
            ovr_q   <= ovr_n;
        end
    end

    assign conv_o  = conv_q;
    assign shift_o = shift_q;
    assign filt_o  = filt_q;
    assign dds_o   = dds_q;
    assign ovr_o   = ovr_q;

    // R10
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({conv_q, shift_q, filt_q, dds_q}));

    // R10
    conv_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        conv_q |=> !conv_q);

    // R10
    dds_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dds_q |=> !dds_q);

    // R8
    ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovr_q |=> ovr_q);

    // R9
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !(conv_q || shift_q || filt_q || dds_q));

    // R5
    dds_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dds_q |-> (st_q == ST_DONE && $past(st_q) inside {ST_SETTLE, ST_READY}));

endmodule

// File: rtl/servo_cycle_seq.sv
module servo_cycle_seq #(
    parameter int N_CH        = 16,
    parameter int CYCLE_LEN   = 64,
    parameter int CONV_AT     = 0,
    parameter int SHIFT_AT    = 4,
    parameter int FILT_LATEST = 30,
    parameter int DDS_AT      = 56
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    en_i,
    input  logic                    cap_done_i,
    input  logic                    filt_done_i,
    output logic                    conv_o,
    output logic                    shift_o,
    output logic                    filt_start_o,
    output logic                    dds_start_o,
    output logic [$clog2(N_CH)-1:0] chan_o,
    output logic                    chan_vld_o,
    output logic                    ovr_o
);

    localparam int CNT_W = $clog2(CYCLE_LEN);
    localparam int CH_W  = $clog2(N_CH);

    logic [CNT_W-1:0] cnt_nxt;
    logic             go_walk;
    logic             walk_last;

    svc_slot_counter #(
        .CYCLE_LEN (CYCLE_LEN),
        .CNT_W     (CNT_W)
    ) u_counter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_i),
        .cnt_nxt_o (cnt_nxt)
    );

    svc_phase_fsm #(
        .CYCLE_LEN   (CYCLE_LEN),
        .CONV_AT     (CONV_AT),
        .SHIFT_AT    (SHIFT_AT),
        .FILT_LATEST (FILT_LATEST),
        .DDS_AT      (DDS_AT),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_i),
        .cnt_nxt_i   (cnt_nxt),
        .cap_done_i  (cap_done_i),
        .filt_done_i (filt_done_i),
        .walk_last_i (walk_last),
        .go_walk_o   (go_walk),
        .conv_o      (conv_o),
        .shift_o     (shift_o),
        .filt_o      (filt_start_o),
        .dds_o       (dds_start_o),
        .ovr_o       (ovr_o)
    );

    svc_chan_walker #(
        .N_CH (N_CH),
        .CH_W (CH_W)
    ) u_walker (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .go_i   (go_walk),
        .addr_o (chan_o),
        .vld_o  (chan_vld_o),
        .last_o (walk_last)
    );

    // R4
    walk_begins_with_filt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        filt_start_o |-> (chan_vld_o && chan_o == '0));

    // R6
    no_walk_after_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovr_o) |-> !chan_vld_o);

endmodule

// File: tb/servo_cycle_seq_tb.sv
module servo_cycle_seq_tb_top;

    localparam int NCH = 16;
    localparam int CYC = 64;
    localparam int SH  = 4;
    localparam int FL  = 30;
    localparam int DDS = 56;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic cap = 1'b0;
    logic fdone = 1'b0;
    logic conv, shift, filt, dds, vld, ovr;
    logic [$clog2(NCH)-1:0] chan;

    int  tests = 0;
    int  fails = 0;
    bit  finished = 1'b0;

    servo_cycle_seq #(
        .N_CH (NCH), .CYCLE_LEN (CYC), .CONV_AT (0),
        .SHIFT_AT (SH), .FILT_LATEST (FL), .DDS_AT (DDS)
    ) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .en_i (en),
        .cap_done_i (cap), .filt_done_i (fdone),
        .conv_o (conv), .shift_o (shift), .filt_start_o (filt),
        .dds_start_o (dds), .chan_o (chan), .chan_vld_o (vld), .ovr_o (ovr)
    );

    // Columns: capture slot, filter-done slot (-1 never),
    // expected filter-start slot (-1 none), expect DDS, expected overrun slot.
    localparam int VEC [8][5] = '{
        '{ 6, 25,  7, 1, -1},
        '{ 4, 21,  5, 1, -1},
        '{29, 55, 30, 1, -1},
        '{30, 50, -1, 0, 31},
        '{10, 56, 11, 0, 56},
        '{10, -1, 11, 0, 56},
        '{ 2, 40, -1, 0, 31},
        '{12, 20, 13, 0, 56}
    };

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        en = 1'b0; cap = 1'b0; fdone = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_row(input int c, input int f, input int ef,
                           input int ed, input int eo);
        int n_conv = 0, conv_ends = 0, shift_slot = -1, n_shift = 0;
        int filt_slot = -1, n_filt = 0, dds_slot = -1, n_dds = 0;
        int ovr_first = -1, vld_n = 0, vld_first = -1, chan_bad = 0, wide = 0;
        int ovr_end;
        bit pc = 0, ps = 0, pf = 0, pd = 0;
        string tag;
        do_reset();
        en = 1'b1;
        for (int s = 0; s <= CYC; s++) begin
            @(negedge clk);
            if (conv) begin n_conv++; if (s == 0 || s == CYC) conv_ends++; end
            if (shift) begin n_shift++; shift_slot = s; end
            if (filt) begin n_filt++; filt_slot = s; end
            if (dds) begin n_dds++; dds_slot = s; end
            if (ovr && ovr_first < 0) ovr_first = s;
            if (vld) begin
                vld_n++;
                if (vld_first < 0) vld_first = s;
                if (int'(chan) != s - ef) chan_bad++;
            end
            if ((conv && pc) || (shift && ps) || (filt && pf) || (dds && pd)) wide++;
            pc = conv; ps = shift; pf = filt; pd = dds;
            cap   = (s == c);
            fdone = (s == f);
        end
        ovr_end = int'(ovr);
        cap = 1'b0; fdone = 1'b0; en = 1'b0;
        tag = (eo == FL + 1) ? "R6" : ((eo == DDS) ? "R7" : "R5");
        chk("R1 convert pulse count", n_conv, 2);
        chk("R1 convert at slot 0 and after wrap", conv_ends, 2);
        chk("R2 shift start slot", shift_slot, SH);
        chk("R2 shift pulse count", n_shift, 1);
        chk("R3 filter start slot", filt_slot, ef);
        chk("R3 filter start count", n_filt, (ef >= 0) ? 1 : 0);
        chk("R4 valid cycle count", vld_n, (ef >= 0) ? NCH : 0);
        chk("R4 walk first slot", vld_first, ef);
        chk("R4 address order", chan_bad, 0);
        chk({tag, " DDS start slot"}, dds_slot, (ed != 0) ? DDS : -1);
        chk({tag, " DDS start count"}, n_dds, ed);
        chk({tag, " overrun first slot"}, ovr_first, eo);
        if (eo >= 0) chk("R8 overrun held into next iteration", ovr_end, 1);
        chk("R10 strobe wider than one clock", wide, 0);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int busy;
        // R11: outputs zero while reset is held
        @(negedge clk);
        chk("R11 outputs during reset",
            int'({conv, shift, filt, dds, vld, ovr, chan}), 0);

        // R9: enable low keeps everything quiet
        rst_n = 1'b1;
        busy = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (conv || shift || filt || dds || vld) busy++;
        end
        chk("R9 no activity while disabled", busy, 0);

        // Vector table walk (R1-related checks per row)
        for (int i = 0; i < 8; i++) begin
            run_row(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
        end

        // R9: drop enable mid-walk, then restart from slot 0
        do_reset();
        en = 1'b1;
        for (int s = 0; s <= 20; s++) begin
            @(negedge clk);
            cap = (s == 10);
        end
        chk("R4 address walk active before disable", int'(vld), 1);
        cap = 1'b0;
        en = 1'b0;
        busy = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (conv || shift || filt || dds || vld) busy++;
        end
        chk("R9 activity stops when disabled", busy, 0);
        en = 1'b1;
        @(negedge clk);
        chk("R9 convert in first enabled cycle", int'(conv), 1);
        repeat (SH) @(negedge clk);
        chk("R9 shift start four slots after restart", int'(shift), 1);
        chk("R8 disable is not an overrun", int'(ovr), 0);
        en = 1'b0;

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule